// File: doc/BRIEF.md
# Prescaled Up/Down Reload Timer

This block is a 16-bit counter with a reload value. It advances only on a count-enable pulse. A two-bit clock select in a configuration register picks where that pulse comes from: the system clock itself, the system clock divided by 2 or by 12, or an asynchronous external clock divided by 8. The external clock is first brought into the system clock domain.

Each time the counter wraps, an internal toggle flop inverts. When the output enable is set, the toggle flop drives an output pin as a 50% duty square wave whose period follows the reload value. A decrement-enable bit lets a direction input choose between counting up and counting down. When that bit is clear, the direction input is ignored.

Software reaches the block through one 16-bit register port. The port has a synchronous write strobe and a combinational read.

The port has three addresses:
- Address 0 is the configuration register. Its bits are: 0 decrement enable, 1 output enable, 2 toggle state, [4:3] clock select. All other bits are reserved.
- Address 1 is the count.
- Address 2 is the reload value.

The clock select codes are:
- 00: system clock / 12
- 01: system clock
- 10: external clock / 8
- 11: system clock / 2

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset, the configuration, count and reload all read 0, and `pinOut` and `pinOe` are both 0.
- R2: Configuration bits above bit 4 read as 0, and any value written to them is discarded.
- R3: With clock select 01, the count changes on every system clock edge.
- R4: With clock select 11, the count changes on every second edge. With clock select 00, it changes on every twelfth edge.
- R5: With clock select 10, the count changes once per eight rising edges of `extClk`, after those edges pass a synchronizer.
- R6: With decrement enable (bit 0) at 0, the timer counts up whatever level `dirIn` has.
- R7: With decrement enable at 1, the timer counts down while `dirIn` is 0 and up while `dirIn` is 1.
- R8: Counting up, a step from 0xFFFF loads the reload value and inverts the toggle state.
- R9: Counting down, a step taken while the count equals the reload value loads 0xFFFF and inverts the toggle state.
- R10: `pinOe` follows output enable (bit 1). `pinOut` equals the toggle state while output enable is 1, and is 0 otherwise.
- R11: Configuration bit 2 reads back the toggle state. A configuration write sets the toggle state to the written bit 2.
- R12: A configuration write that changes the clock select restarts the prescaler. With divisor N, the first count step then falls on the N-th edge after that write.
- R13: A write to the count or reload address takes effect on that edge. A count write takes priority over a count step on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| extClk | input | 1 | Asynchronous external count clock |
| dirIn | input | 1 | Count direction when decrement is enabled (1 = up) |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 config, 1 count, 2 reload) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from `regAddr` |
| pinOut | output | 1 | Square-wave output level |
| pinOe | output | 1 | Output enable for the square-wave pin |

## Verification
The checker holds the following on every cycle:
- A single step moves the count by exactly one in the selected direction.
- Both wrap cases (R8 and R9) load the right value and flip the toggle state.
- The pin follows the toggle state and the enable.
- Reserved configuration bits read zero.
- At half rate, no two count-enable pulses come back to back.

Some behaviours can only be shown by the bench's scenarios:
- The exact phase of the first step after a clock-select change.
- The divide-by-12 and divide-by-8 external rates.
- The forcing of the toggle state.

For each of these, the bench reads the count after a known number of edges or external pulses.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_RLD = 2'd2;

  typedef enum logic [1:0] {
    SEL_SLOW = 2'b00,
    SEL_FULL = 2'b01,
    SEL_EXT  = 2'b10,
    SEL_HALF = 2'b11
  } clkSel_e;

  localparam int CFG_DEC = 0;
  localparam int CFG_OE  = 1;
  localparam int CFG_TOG = 2;
  localparam int CFG_SLO = 3;
  localparam int CFG_SHI = 4;

  localparam int CNT_W = 16;

  typedef struct packed {
    logic             tick;
    logic             down;
    logic             ldCnt;
    logic             ldRld;
    logic             ldTog;
    logic             togVal;
    logic [CNT_W-1:0] data;
  } rtmStrobes_t;

endpackage

// File: rtl/rtm_ctrl.sv
module rtm_ctrl
  import reload_timer_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_HALF    = 2,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extClk,
  input  logic             dirIn,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] rldQ,
  input  logic             togQ,
  output logic [CNT_W-1:0] regRdata,
  output rtmStrobes_t      strb,
  output clkSel_e          cfgSel,
  output logic             cfgOe,
  output logic             cfgDec
);

  localparam int DIV_MAX0 = (DIV_SLOW > DIV_HALF) ? DIV_SLOW : DIV_HALF;
  localparam int DIV_MAX  = (DIV_MAX0 > DIV_EXT) ? DIV_MAX0 : DIV_EXT;
  localparam int DW       = $clog2(DIV_MAX + 1);
  localparam int PIPE_W   = SYNC_STAGES + 1;

  // synchronizer plus one edge-detect stage
  logic [PIPE_W-1:0] extPipe;
  logic              extRise;

  always_ff @(posedge clk) begin
    if (rst) extPipe <= '0;
    else     extPipe <= {extPipe[PIPE_W-2:0], extClk};
  end

  assign extRise = extPipe[PIPE_W-2] & ~extPipe[PIPE_W-1];

  // configuration register
  logic    cfgWr;
  clkSel_e newSel;
  logic    selChange;

  assign cfgWr     = regWe && (regAddr == ADDR_CFG);
  assign newSel    = clkSel_e'(regWdata[CFG_SHI:CFG_SLO]);
  assign selChange = cfgWr && (newSel != cfgSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgSel <= SEL_SLOW;
      cfgOe  <= 1'b0;
      cfgDec <= 1'b0;
    end else if (cfgWr) begin
      cfgSel <= newSel;
      cfgOe  <= regWdata[CFG_OE];
      cfgDec <= regWdata[CFG_DEC];
    end
  end

  // prescaler
  logic [DW-1:0] divCnt;
  logic [DW-1:0] spanLast;
  logic          stepEn;
  logic          tick;

  always_comb begin
    stepEn = 1'b1;
    unique case (cfgSel)
      SEL_SLOW: spanLast = DW'(DIV_SLOW - 1);
      SEL_FULL: spanLast = '0;
      SEL_HALF: spanLast = DW'(DIV_HALF - 1);
      SEL_EXT: begin
        spanLast = DW'(DIV_EXT - 1);
        stepEn   = extRise;
      end
      default:  spanLast = '0;
    endcase
  end

  assign tick = stepEn && (divCnt == spanLast);

  always_ff @(posedge clk) begin
    if (rst || selChange) divCnt <= '0;
    else if (stepEn)      divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  // strobes to the datapath
  always_comb begin
    strb.tick   = tick;
    strb.down   = cfgDec & ~dirIn;
    strb.ldCnt  = regWe && (regAddr == ADDR_CNT);
    strb.ldRld  = regWe && (regAddr == ADDR_RLD);
    strb.ldTog  = cfgWr;
    strb.togVal = regWdata[CFG_TOG];
    strb.data   = regWdata;
  end

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CFG: begin
        regRdata[CFG_SHI:CFG_SLO] = cfgSel;
        regRdata[CFG_TOG]         = togQ;
        regRdata[CFG_OE]          = cfgOe;
        regRdata[CFG_DEC]         = cfgDec;
      end
      ADDR_CNT: regRdata = cntQ;
      ADDR_RLD: regRdata = rldQ;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/rtm_datapath.sv
module rtm_datapath
  import reload_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  rtmStrobes_t      strb,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] rldQ,
  output logic             togQ
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic atEdge;
  logic wrapEv;

  assign atEdge = strb.down ? (cntQ == rldQ) : (cntQ == ALL_ONES);
  assign wrapEv = strb.tick && !strb.ldCnt && atEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (strb.ldCnt) begin
      cntQ <= strb.data;
    end else if (strb.tick) begin
      if (strb.down) cntQ <= atEdge ? ALL_ONES : cntQ - 1'b1;
      else           cntQ <= atEdge ? rldQ     : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rldQ <= '0;
    else if (strb.ldRld) rldQ <= strb.data;
  end

  always_ff @(posedge clk) begin
    if (rst)             togQ <= 1'b0;
    else if (strb.ldTog) togQ <= strb.togVal;
    else if (wrapEv)     togQ <= ~togQ;
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_HALF    = 2,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        extClk,
  input  logic        dirIn,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        pinOut,
  output logic        pinOe
);

  rtmStrobes_t      strb;
  clkSel_e          cfgSel;
  logic             cfgOe;
  logic             cfgDec;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] rldQ;
  logic             togQ;

  rtm_ctrl #(
    .DIV_SLOW(DIV_SLOW), .DIV_HALF(DIV_HALF),
    .DIV_EXT(DIV_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .extClk(extClk), .dirIn(dirIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .cntQ(cntQ), .rldQ(rldQ), .togQ(togQ),
    .regRdata(regRdata), .strb(strb),
    .cfgSel(cfgSel), .cfgOe(cfgOe), .cfgDec(cfgDec)
  );

  rtm_datapath dp_i (
    .clk(clk), .rst(rst), .strb(strb),
    .cntQ(cntQ), .rldQ(rldQ), .togQ(togQ)
  );

  assign pinOe  = cfgOe;
  assign pinOut = cfgOe & togQ;

endmodule

// File: rtl/rtm_checker.sv
module rtm_checker (
  input logic        clk,
  input logic        rst,
  input logic        regWe,
  input logic [1:0]  regAddr,
  input logic [15:0] regRdata,
  input logic        dirIn,
  input logic        tick,
  input logic [1:0]  cfgSel,
  input logic        cfgDec,
  input logic [15:0] cntQ,
  input logic [15:0] rldQ,
  input logic        togQ,
  input logic        pinOut,
  input logic        pinOe
);

  logic goDown;
  assign goDown = cfgDec & ~dirIn;

  AST_RSV_READ: assert property (@(posedge clk) disable iff (rst)
    (regAddr == 2'd0) |-> (regRdata[15:5] == '0)); // R2

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    (cfgSel == 2'b11 && tick && !regWe) |=> !tick); // R4

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !regWe && !goDown && cntQ != 16'hFFFF)
      |=> (cntQ == $past(cntQ) + 16'd1)); // R6

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !regWe && goDown && cntQ != rldQ)
      |=> (cntQ == $past(cntQ) - 16'd1)); // R7

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !regWe && !goDown && cntQ == 16'hFFFF)
      |=> (cntQ == $past(rldQ) && togQ != $past(togQ))); // R8

  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !regWe && goDown && cntQ == rldQ)
      |=> (cntQ == 16'hFFFF && togQ != $past(togQ))); // R9

  AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    pinOe |-> (pinOut == togQ)); // R10

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pinOe |-> !pinOut); // R10

endmodule

bind reload_timer rtm_checker chk_i (
  .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
  .regRdata(regRdata), .dirIn(dirIn), .tick(strb.tick),
  .cfgSel(cfgSel), .cfgDec(cfgDec), .cntQ(cntQ), .rldQ(rldQ),
  .togQ(togQ), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        extClk = 1'b0;
  logic        dirIn = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        pinOut;
  logic        pinOe;

  always #4 clk = ~clk; // 125 MHz

  reload_timer dut_i (
    .clk(clk), .rst(rst), .extClk(extClk), .dirIn(dirIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .pinOut(pinOut), .pinOe(pinOe)
  );

  typedef struct {
    int          kind;  // 0 read port, 1 pinOut, 2 pinOe
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          1:       act = {15'd0, pinOut};
          2:       act = {15'd0, pinOe};
          default: act = regRdata;
        endcase
        vectors++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input int kind, input logic [1:0] addr,
                           input logic [15:0] exp, input string req);
    item_t it;
    @(negedge clk);
    regAddr = addr;
    #1;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    ->sampleEv;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [15:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = addr; regWdata = data;
    @(posedge clk);
    #1 regWe = 1'b0;
  endtask

  // write config twice so the select always changes, then load count
  task automatic startRun(input logic [15:0] cfgVal, input logic [15:0] v);
    wr(2'd0, cfgVal ^ 16'h0008);
    wr(2'd0, cfgVal);
    wr(2'd1, v);
  endtask

  function automatic int ticksFor(input int n, input int m);
    int t = 0;
    for (int k = 2; k <= m + 1; k++) if (k % n == 0) t++;
    return t;
  endfunction

  function automatic logic [16:0] model(input logic [15:0] c, input logic [15:0] r,
                                        input logic dn, input int n);
    logic [15:0] cc = c;
    logic        t = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (dn) begin
        if (cc == r) begin cc = 16'hFFFF; t = ~t; end
        else cc = cc - 16'd1;
      end else begin
        if (cc == 16'hFFFF) begin cc = r; t = ~t; end
        else cc = cc + 16'd1;
      end
    end
    return {t, cc};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    expectVal(0, 2'd0, 16'h0000, "R1 cfg");
    expectVal(0, 2'd1, 16'h0000, "R1 count");
    expectVal(0, 2'd2, 16'h0000, "R1 reload");
    expectVal(1, 2'd0, 16'h0000, "R1 pinOut");
    expectVal(2, 2'd0, 16'h0000, "R1 pinOe");

    // R2 reserved bits, R11 force toggle high, R10 pin drive
    wr(2'd0, 16'hFFFF);
    expectVal(0, 2'd0, 16'h001F, "R2 reserved read");
    expectVal(1, 2'd0, 16'h0001, "R10 pinOut with oe");
    expectVal(2, 2'd0, 16'h0001, "R10 pinOe");
    wr(2'd0, 16'hFFE8);
    expectVal(0, 2'd0, 16'h0008, "R2 reserved write ignored");

    // R3 full rate, R6 dirIn ignored without decrement enable
    dirIn = 1'b0;
    startRun(16'h0008, 16'h1000);
    repeat (20) @(posedge clk);
    expectVal(0, 2'd1, 16'h1000 + 16'(ticksFor(1, 20)), "R3 R6 full rate up");

    // R4 half rate
    startRun(16'h0018, 16'h2000);
    repeat (21) @(posedge clk);
    expectVal(0, 2'd1, 16'h2000 + 16'(ticksFor(2, 21)), "R4 half rate");

    // R4 R12 divide by 12, phase restart after select change
    startRun(16'h0000, 16'h3000);
    repeat (50) @(posedge clk);
    expectVal(0, 2'd1, 16'h3000 + 16'(ticksFor(12, 50)), "R4 R12 div12");

    // R12 first step phase at half rate: after 1 edge none, after 2 one
    startRun(16'h0018, 16'h4000);
    repeat (1) @(posedge clk);
    expectVal(0, 2'd1, 16'h4000 + 16'(ticksFor(2, 1)), "R12 half phase");

    // R7 down and up with decrement enable
    dirIn = 1'b0;
    startRun(16'h0009, 16'h0100);
    repeat (10) @(posedge clk);
    expectVal(0, 2'd1, 16'h00F6, "R7 count down");
    dirIn = 1'b1;
    startRun(16'h0009, 16'h0100);
    repeat (10) @(posedge clk);
    expectVal(0, 2'd1, 16'h010A, "R7 count up");

    // R8 up overflow reload and toggle, R13 reload write
    dirIn = 1'b0;
    wr(2'd2, 16'hFFF0);
    expectVal(0, 2'd2, 16'hFFF0, "R13 reload write");
    startRun(16'h000A, 16'hFFFD);
    repeat (5) @(posedge clk);
    m = model(16'hFFFD, 16'hFFF0, 1'b0, 5);
    expectVal(0, 2'd1, m[15:0], "R8 up wrap count");
    expectVal(0, 2'd0, {13'd0, m[16], 2'b10} | 16'h0008, "R8 R11 toggle read");
    expectVal(1, 2'd0, {15'd0, m[16]}, "R8 R10 pinOut");

    // R9 down wrap
    wr(2'd2, 16'h0010);
    startRun(16'h000B, 16'h0012);
    repeat (5) @(posedge clk);
    m = model(16'h0012, 16'h0010, 1'b1, 5);
    expectVal(0, 2'd1, m[15:0], "R9 down wrap count");
    expectVal(0, 2'd0, {13'd0, m[16], 2'b11} | 16'h0008, "R9 toggle read");

    // R10 pin gated off while toggle high; R11 force low
    wr(2'd0, 16'h0004);
    expectVal(1, 2'd0, 16'h0000, "R10 pinOut gated");
    expectVal(2, 2'd0, 16'h0000, "R10 pinOe off");
    expectVal(0, 2'd0, 16'h0004, "R11 toggle forced high");
    wr(2'd0, 16'h0002);
    expectVal(0, 2'd0, 16'h0002, "R11 toggle forced low");
    expectVal(1, 2'd0, 16'h0000, "R11 pinOut low");

    // R5 external clock divided by 8
    extClk = 1'b0;
    startRun(16'h0010, 16'h0500);
    for (int p = 0; p < 20; p++) begin
      @(negedge clk) extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    expectVal(0, 2'd1, 16'h0502, "R5 external div8");

    // R13 count write wins over step
    startRun(16'h0008, 16'h7777);
    expectVal(0, 2'd1, 16'h7777, "R13 count write priority");

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule